// File: doc/BRIEF.md
# Byte-Count Audio DMA Channel

This block moves audio sample data for one direction between system memory and an audio stream. Software loads a word-aligned memory address, a byte count still to be moved and an enable bit. Each time the audio side signals a service opportunity, it reports how many bytes it can take (playback) or offer (capture). The channel then moves the smaller of that figure and its remaining count, one 32-bit word at a time. The work is split into chunks of at most `CHUNK_BYTES`.

Each moved word advances the address by four and lowers the remaining count by four. Software can read both values back at any time. When an opportunity ends with the channel enabled and the count at exactly zero, the channel pulses a completion interrupt.

Software writes that arrive while a transfer runs are held back. They are applied at the next chunk boundary, and the opportunity ends there. A parameter selects the playback variant (memory read, stream out) or the capture variant (stream in, memory write).

Top module: `audio_dma_channel`

## Requirements
- R1: After reset, `en_o`, `addr_o`, `remain_o`, `busy_o` and `irq_done_o` are all zero, and no memory request or stream handshake is active.
- R2: `cfg_sel` selects the register written by `cfg_we`: 0 is control (bit 0 = enable), 1 is address, 2 is remaining count, and 3 has no effect. While the channel is idle, a write shows on the read-back outputs one cycle later. Bits 1:0 of the address and of the count are forced to zero.
- R3: On a service opportunity (`svc_valid`) with the channel enabled, the transfer length is the minimum of `remain_o` and `svc_bytes` rounded down to a multiple of 4.
- R4: A service opportunity is ignored when the channel is disabled or the computed length is zero. In that case there is no transfer, no interrupt and no register change, and no memory or stream activity happens while `busy_o` is low.
- R5: Each word moved raises `addr_o` by 4 and lowers `remain_o` by 4. In playback, the words are read from consecutive addresses starting at the loaded address and presented on `play_data` in that order.
- R6: No chunk exceeds `CHUNK_BYTES`. At each chunk boundary `svc_dry` is sampled, and if it is high the opportunity ends after the bytes already moved.
- R7: `irq_done_o` pulses for exactly one cycle when an opportunity ends with the enable set and the remaining count at zero, and at no other time.
- R8: A configuration write made while `busy_o` is high is deferred to the end of the current chunk, and the opportunity ends there. For each register, the last deferred write wins over the address and count advance.
- R9: While `play_valid` is high and `play_ready` is low, `play_valid` stays high and `play_data` stays unchanged.
- R10: `en_o` reflects the enable bit and activates the audio stream. Clearing it during a transfer stops the transfer at the chunk boundary and suppresses the completion interrupt, even if the count reaches zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select for the write |
| cfg_wdata | input | 32 | Write data |
| en_o | output | 1 | Enable bit; audio stream active |
| addr_o | output | ADDR_W | Current memory byte address |
| remain_o | output | CNT_W | Remaining byte count |
| busy_o | output | 1 | Transfer in progress |
| irq_done_o | output | 1 | Completion interrupt pulse |
| svc_valid | input | 1 | Service opportunity strobe |
| svc_bytes | input | AVAIL_W | Bytes the audio side can take or offer |
| svc_dry | input | 1 | Audio side has nothing more this opportunity |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Request byte address |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| play_valid | output | 1 | Playback word valid |
| play_data | output | 32 | Playback word |
| play_ready | input | 1 | Audio side accepts the playback word |
| cap_valid | input | 1 | Capture word valid |
| cap_data | input | 32 | Capture word |
| cap_ready | output | 1 | Channel accepts the capture word |

## Verification
The bench builds the playback variant with `CHUNK_BYTES` at 16, `CNT_W` at 16 and `AVAIL_W` at 12. The small chunk means a single opportunity crosses several chunk boundaries, so the chunk gap, the dry stop and the deferred-write stop are all exercised with short transfers. The narrow count and availability widths let random counts, availabilities and misaligned values land often on zero-length, exact-zero and rounding cases. Random grant and ready stalls exercise the stable-hold rule on the playback stream.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

   localparam int WORD_BYTES = 4;
   localparam int DATA_W     = 32;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_FILL  = 3'd1,
      ST_DRAIN = 3'd2,
      ST_GAP   = 3'd3,
      ST_FIN   = 3'd4
   } dma_state_t;

   typedef enum logic [1:0] {
      SEL_CTRL   = 2'd0,
      SEL_ADDR   = 2'd1,
      SEL_REMAIN = 2'd2,
      SEL_NONE   = 2'd3
   } cfg_sel_t;

endpackage

// File: rtl/dma_len_calc.sv
module dma_len_calc
   import dma_chan_pkg::*;
#(
   parameter int CNT_W   = 24,
   parameter int AVAIL_W = 16
) (
   input  logic               svc_valid,
   input  logic               en_q,
   input  logic [CNT_W-1:0]   rem_q,
   input  logic [AVAIL_W-1:0] svc_bytes,
   output logic [CNT_W-1:0]   len,
   output logic               start
);

   localparam logic [CNT_W-1:0] LOW_MASK = ~CNT_W'(WORD_BYTES - 1);

   logic [CNT_W-1:0] avail_ext;

   always_comb begin
      avail_ext = CNT_W'(svc_bytes) & LOW_MASK;
      len       = (rem_q < avail_ext) ? rem_q : avail_ext;
      start     = svc_valid && en_q && (len != '0);
   end

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
   import dma_chan_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [31:0]       cfg_wdata,
   input  logic              busy,
   input  logic              apply,
   input  logic              adv,
   output logic              en_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [CNT_W-1:0]  rem_q,
   output logic              pend_any
);

   localparam logic [ADDR_W-1:0] A_MASK = ~ADDR_W'(WORD_BYTES - 1);
   localparam logic [CNT_W-1:0]  C_MASK = ~CNT_W'(WORD_BYTES - 1);
   localparam logic [ADDR_W-1:0] A_STEP = ADDR_W'(WORD_BYTES);
   localparam logic [CNT_W-1:0]  C_STEP = CNT_W'(WORD_BYTES);

   logic              pv_en, pv_addr, pv_rem;
   logic              pd_en;
   logic [ADDR_W-1:0] pd_addr;
   logic [CNT_W-1:0]  pd_rem;
   logic [ADDR_W-1:0] wr_addr;
   logic [CNT_W-1:0]  wr_rem;
   cfg_sel_t          sel;

   assign wr_addr  = cfg_wdata[ADDR_W-1:0] & A_MASK;
   assign wr_rem   = cfg_wdata[CNT_W-1:0] & C_MASK;
   assign sel      = cfg_sel_t'(cfg_sel);
   assign pend_any = pv_en | pv_addr | pv_rem;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         addr_q  <= '0;
         rem_q   <= '0;
         pv_en   <= 1'b0;
         pv_addr <= 1'b0;
         pv_rem  <= 1'b0;
         pd_en   <= 1'b0;
         pd_addr <= '0;
         pd_rem  <= '0;
      end else begin
         if (adv) begin
            addr_q <= addr_q + A_STEP;
            rem_q  <= rem_q - C_STEP;
         end
         if (apply) begin
            if (pv_en)   en_q   <= pd_en;
            if (pv_addr) addr_q <= pd_addr;
            if (pv_rem)  rem_q  <= pd_rem;
            pv_en   <= 1'b0;
            pv_addr <= 1'b0;
            pv_rem  <= 1'b0;
         end
         if (cfg_we && !busy) begin
            case (sel)
               SEL_CTRL:   en_q   <= cfg_wdata[0];
               SEL_ADDR:   addr_q <= wr_addr;
               SEL_REMAIN: rem_q  <= wr_rem;
               default: ;
            endcase
         end else if (cfg_we) begin
            case (sel)
               SEL_CTRL: begin
                  pv_en <= 1'b1;
                  pd_en <= cfg_wdata[0];
               end
               SEL_ADDR: begin
                  pv_addr <= 1'b1;
                  pd_addr <= wr_addr;
               end
               SEL_REMAIN: begin
                  pv_rem <= 1'b1;
                  pd_rem <= wr_rem;
               end
               default: ;
            endcase
         end
      end
   end

   AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_q[1:0] == 2'b00) && (rem_q[1:0] == 2'b00)); // R2

   AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> (addr_q == $past(addr_q) + A_STEP) && (rem_q == $past(rem_q) - C_STEP)); // R5

   AST_DEFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !apply && !adv) |=> $stable(addr_q) && $stable(rem_q) && $stable(en_q)); // R8

endmodule

// File: rtl/dma_burst_engine.sv
module dma_burst_engine
   import dma_chan_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int CNT_W       = 24,
   parameter int CHUNK_BYTES = 4096,
   parameter bit CAPTURE     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CNT_W-1:0]  len,
   input  logic              dry,
   input  logic              pend_any,
   input  logic              en_q,
   input  logic [CNT_W-1:0]  rem_q,
   input  logic [ADDR_W-1:0] addr_q,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic              mem_gnt,
   input  logic [31:0]       mem_rdata,
   output logic              play_valid,
   output logic [31:0]       play_data,
   input  logic              play_ready,
   input  logic              cap_valid,
   input  logic [31:0]       cap_data,
   output logic              cap_ready,
   output logic              busy,
   output logic              apply,
   output logic              adv,
   output logic              irq
);

   localparam logic [CNT_W-1:0] CHUNK_C = CNT_W'(CHUNK_BYTES);
   localparam logic [CNT_W-1:0] STEP_C  = CNT_W'(WORD_BYTES);

   dma_state_t        state_q;
   logic [CNT_W-1:0]  total_q;
   logic [CNT_W-1:0]  chunk_q;
   logic [31:0]       hold_q;
   logic [31:0]       fill_data;
   logic              fill_ok;
   logic              drain_ok;
   logic              in_fill;
   logic              in_drain;
   logic              irq_q;

   function automatic logic [CNT_W-1:0] clip_chunk(input logic [CNT_W-1:0] n);
      return (n < CHUNK_C) ? n : CHUNK_C;
   endfunction

   assign in_fill  = (state_q == ST_FILL);
   assign in_drain = (state_q == ST_DRAIN);
   assign busy     = (state_q != ST_IDLE);
   assign apply    = (state_q == ST_IDLE) || (state_q == ST_GAP);
   assign adv      = drain_ok;
   assign irq      = irq_q;
   assign mem_addr = addr_q;

   generate
      if (CAPTURE) begin : g_capture
         logic [31:0] unused_rd;
         logic        unused_rdy;
         assign unused_rd  = mem_rdata;
         assign unused_rdy = play_ready;
         assign cap_ready  = in_fill;
         assign fill_ok    = in_fill && cap_valid;
         assign fill_data  = cap_data;
         assign mem_req    = in_drain;
         assign mem_we     = 1'b1;
         assign mem_wdata  = hold_q;
         assign drain_ok   = in_drain && mem_gnt;
         assign play_valid = 1'b0;
         assign play_data  = '0;
      end else begin : g_playback
         logic [31:0] unused_cd;
         logic        unused_cv;
         assign unused_cd  = cap_data;
         assign unused_cv  = cap_valid;
         assign cap_ready  = 1'b0;
         assign mem_req    = in_fill;
         assign mem_we     = 1'b0;
         assign mem_wdata  = '0;
         assign fill_ok    = in_fill && mem_gnt;
         assign fill_data  = mem_rdata;
         assign play_valid = in_drain;
         assign play_data  = hold_q;
         assign drain_ok   = in_drain && play_ready;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         total_q <= '0;
         chunk_q <= '0;
         hold_q  <= '0;
         irq_q   <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  total_q <= len;
                  chunk_q <= clip_chunk(len);
                  state_q <= ST_FILL;
               end
            end
            ST_FILL: begin
               if (fill_ok) begin
                  hold_q  <= fill_data;
                  state_q <= ST_DRAIN;
               end
            end
            ST_DRAIN: begin
               if (drain_ok) begin
                  total_q <= total_q - STEP_C;
                  chunk_q <= chunk_q - STEP_C;
                  state_q <= (chunk_q == STEP_C) ? ST_GAP : ST_FILL;
               end
            end
            ST_GAP: begin
               if ((total_q == '0) || pend_any || dry) begin
                  state_q <= ST_FIN;
               end else begin
                  chunk_q <= clip_chunk(total_q);
                  state_q <= ST_FILL;
               end
            end
            ST_FIN: begin
               irq_q   <= en_q && (rem_q == '0);
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   AST_CHUNK_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      chunk_q <= CHUNK_C); // R6

   AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq); // R7

   AST_IRQ_COND: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> en_q && (rem_q == '0)); // R7

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req && !play_valid && !cap_ready); // R4

   AST_PLAY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (play_valid && !play_ready) |=> play_valid && $stable(play_data)); // R9

endmodule

// File: rtl/audio_dma_channel.sv
module audio_dma_channel
   import dma_chan_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int CNT_W       = 24,
   parameter int AVAIL_W     = 16,
   parameter int CHUNK_BYTES = 4096,
   parameter bit CAPTURE     = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [1:0]         cfg_sel,
   input  logic [31:0]        cfg_wdata,
   output logic               en_o,
   output logic [ADDR_W-1:0]  addr_o,
   output logic [CNT_W-1:0]   remain_o,
   output logic               busy_o,
   output logic               irq_done_o,
   input  logic               svc_valid,
   input  logic [AVAIL_W-1:0] svc_bytes,
   input  logic               svc_dry,
   output logic               mem_req,
   output logic               mem_we,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [31:0]        mem_wdata,
   input  logic               mem_gnt,
   input  logic [31:0]        mem_rdata,
   output logic               play_valid,
   output logic [31:0]        play_data,
   input  logic               play_ready,
   input  logic               cap_valid,
   input  logic [31:0]        cap_data,
   output logic               cap_ready
);

   generate
      if (CHUNK_BYTES < WORD_BYTES || (CHUNK_BYTES % WORD_BYTES) != 0) begin : g_bad_chunk
         $error("CHUNK_BYTES must be a positive multiple of the word size");
      end
      if (AVAIL_W > CNT_W) begin : g_bad_avail
         $error("AVAIL_W must not exceed CNT_W");
      end
      if (ADDR_W > 32 || CNT_W > 32 || ADDR_W < 3 || CNT_W < 3) begin : g_bad_width
         $error("ADDR_W and CNT_W must lie between 3 and 32");
      end
      if (CHUNK_BYTES >= (2 ** CNT_W)) begin : g_bad_fit
         $error("CHUNK_BYTES must fit in CNT_W bits");
      end
   endgenerate

   logic             en_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  rem_q;
   logic             pend_any;
   logic             busy;
   logic             apply;
   logic             adv;
   logic             irq;
   logic             start;
   logic [CNT_W-1:0] len;

   dma_chan_regs #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .busy      (busy),
      .apply     (apply),
      .adv       (adv),
      .en_q      (en_q),
      .addr_q    (addr_q),
      .rem_q     (rem_q),
      .pend_any  (pend_any)
   );

   dma_len_calc #(
      .CNT_W   (CNT_W),
      .AVAIL_W (AVAIL_W)
   ) u_len (
      .svc_valid (svc_valid && !busy),
      .en_q      (en_q),
      .rem_q     (rem_q),
      .svc_bytes (svc_bytes),
      .len       (len),
      .start     (start)
   );

   dma_burst_engine #(
      .ADDR_W      (ADDR_W),
      .CNT_W       (CNT_W),
      .CHUNK_BYTES (CHUNK_BYTES),
      .CAPTURE     (CAPTURE)
   ) u_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .len        (len),
      .dry        (svc_dry),
      .pend_any   (pend_any),
      .en_q       (en_q),
      .rem_q      (rem_q),
      .addr_q     (addr_q),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .mem_gnt    (mem_gnt),
      .mem_rdata  (mem_rdata),
      .play_valid (play_valid),
      .play_data  (play_data),
      .play_ready (play_ready),
      .cap_valid  (cap_valid),
      .cap_data   (cap_data),
      .cap_ready  (cap_ready),
      .busy       (busy),
      .apply      (apply),
      .adv        (adv),
      .irq        (irq)
   );

   assign en_o       = en_q;
   assign addr_o     = addr_q;
   assign remain_o   = rem_q;
   assign busy_o     = busy;
   assign irq_done_o = irq;

endmodule

// File: tb/tb_audio_dma_channel.sv
module tb_audio_dma_channel;

   localparam int AW    = 32;
   localparam int CW    = 16;
   localparam int VW    = 12;
   localparam int CHUNK = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [1:0]    cfg_sel = 2'd0;
   logic [31:0]   cfg_wdata = '0;
   logic          en_o;
   logic [AW-1:0] addr_o;
   logic [CW-1:0] remain_o;
   logic          busy_o;
   logic          irq_done_o;
   logic          svc_valid = 1'b0;
   logic [VW-1:0] svc_bytes = '0;
   logic          svc_dry = 1'b0;
   logic          mem_req;
   logic          mem_we;
   logic [AW-1:0] mem_addr;
   logic [31:0]   mem_wdata;
   logic          mem_gnt = 1'b0;
   logic [31:0]   mem_rdata;
   logic          play_valid;
   logic [31:0]   play_data;
   logic          play_ready = 1'b0;
   logic          cap_valid = 1'b0;
   logic [31:0]   cap_data = '0;
   logic          cap_ready;

   int n_checks = 0;
   int n_fails  = 0;
   int n_words  = 0;
   int n_irq    = 0;
   int cycles   = 0;
   logic [31:0] exp_addr = '0;
   logic        prev_stall = 1'b0;
   logic [31:0] prev_data = '0;

   logic [31:0] m_addr = '0;
   logic [15:0] m_rem  = '0;
   logic        m_en   = 1'b0;

   always #5 clk = ~clk;

   audio_dma_channel #(
      .ADDR_W (AW), .CNT_W (CW), .AVAIL_W (VW), .CHUNK_BYTES (CHUNK), .CAPTURE (1'b0)
   ) dut (
      .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_sel (cfg_sel), .cfg_wdata (cfg_wdata),
      .en_o (en_o), .addr_o (addr_o), .remain_o (remain_o), .busy_o (busy_o),
      .irq_done_o (irq_done_o), .svc_valid (svc_valid), .svc_bytes (svc_bytes),
      .svc_dry (svc_dry), .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr),
      .mem_wdata (mem_wdata), .mem_gnt (mem_gnt), .mem_rdata (mem_rdata),
      .play_valid (play_valid), .play_data (play_data), .play_ready (play_ready),
      .cap_valid (cap_valid), .cap_data (cap_data), .cap_ready (cap_ready)
   );

   function automatic logic [31:0] pat(input logic [31:0] a);
      return {a[15:0], ~a[15:0]} ^ 32'h3C5A_0000;
   endfunction

   function automatic logic [15:0] exp_len(input logic [15:0] rem, input logic [31:0] avail);
      logic [15:0] av;
      av = avail[15:0] & 16'hFFFC;
      return (rem < av) ? rem : av;
   endfunction

   assign mem_rdata = pat(mem_addr);

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // stall generation and stream monitor, all at the falling edge
   always @(negedge clk) begin
      cycles++;
      mem_gnt    = ($urandom % 3) != 0;
      play_ready = ($urandom % 3) != 0;
      if (prev_stall) begin
         chk(play_valid && (play_data == prev_data), "R9 held word", play_data, prev_data);
      end
      if (play_valid && play_ready) begin
         chk(play_data == pat(exp_addr), "R5 stream word", play_data, pat(exp_addr));
         exp_addr = exp_addr + 32'd4;
         n_words++;
      end
      prev_stall = play_valid && !play_ready;
      prev_data  = play_data;
      if (irq_done_o) n_irq++;
      if (cycles > 150000) begin
         n_fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (!busy_o) begin
         if (sel == 2'd0) m_en = d[0];
         if (sel == 2'd1) m_addr = d & 32'hFFFF_FFFC;
         if (sel == 2'd2) m_rem = d[15:0] & 16'hFFFC;
      end
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (busy_o);
      repeat (2) @(negedge clk);
   endtask

   task automatic pulse_svc(input logic [31:0] avail, input bit dry);
      exp_addr = m_addr;
      n_words  = 0;
      n_irq    = 0;
      @(negedge clk);
      svc_valid = 1'b1; svc_bytes = avail[VW-1:0]; svc_dry = dry;
      @(negedge clk);
      svc_valid = 1'b0;
   endtask

   task automatic check_end(input string tag, input logic [15:0] moved, input int irqs);
      m_addr = m_addr + {16'd0, moved};
      m_rem  = m_rem - moved;
      chk(addr_o == m_addr, {tag, " R5 address"}, addr_o, m_addr);
      chk(remain_o == m_rem, {tag, " R5 remaining"}, {16'd0, remain_o}, {16'd0, m_rem});
      chk(n_words * 4 == int'(moved), {tag, " R3 bytes moved"}, n_words * 4, {16'd0, moved});
      chk(n_irq == irqs, {tag, " R7 interrupt count"}, n_irq, irqs);
   endtask

   task automatic run_svc(input logic [31:0] avail, input bit dry, input string tag);
      logic [15:0] l, mv;
      l  = exp_len(m_rem, avail);
      mv = m_en ? l : 16'd0;
      if (dry && mv > 16'(CHUNK)) mv = 16'(CHUNK);
      pulse_svc(avail, dry);
      wait_idle();
      svc_dry = 1'b0;
      check_end(tag, mv, (m_en && l != 0 && (m_rem - mv) == 0) ? 1 : 0);
   endtask

   initial begin
      logic [15:0] l;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!en_o && addr_o == '0 && remain_o == '0, "R1 registers after reset", addr_o, 0);
      chk(!busy_o && !irq_done_o && !mem_req && !play_valid, "R1 idle after reset",
          {28'd0, busy_o, irq_done_o, mem_req, play_valid}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2 alignment and select encoding
      cfg_write(2'd1, 32'h0000_1003);
      chk(addr_o == 32'h1000, "R2 address low bits forced", addr_o, 32'h1000);
      cfg_write(2'd2, 32'h0000_0047);
      chk(remain_o == 16'h0044, "R2 count low bits forced", {16'd0, remain_o}, 32'h44);
      cfg_write(2'd3, 32'hFFFF_FFFF);
      chk(addr_o == 32'h1000 && remain_o == 16'h44 && !en_o, "R2 select 3 no effect",
          addr_o, 32'h1000);

      // R4 disabled opportunity ignored
      run_svc(32'd64, 1'b0, "R4 disabled");
      cfg_write(2'd0, 32'd1);
      chk(en_o, "R10 enable visible", {31'd0, en_o}, 1);

      // R3 length limited by availability, with rounding
      run_svc(32'd23, 1'b0, "R3 avail limited");
      // R4 rounds to zero
      run_svc(32'd3, 1'b0, "R4 zero length");
      // R7 completion: remaining exhausted exactly
      run_svc(32'd400, 1'b0, "R7 exact zero");
      // R4 zero remaining
      run_svc(32'd64, 1'b0, "R4 zero remaining");

      // R6 dry stop at first chunk boundary
      cfg_write(2'd2, 32'd100);
      run_svc(32'd100, 1'b1, "R6 dry stop");

      // R8 deferred writes, last one wins, opportunity ends at the boundary
      cfg_write(2'd1, 32'h0000_2000);
      cfg_write(2'd2, 32'd64);
      l = exp_len(m_rem, 32'd64);
      pulse_svc(32'd64, 1'b0);
      cfg_write(2'd1, 32'h0000_5554);
      cfg_write(2'd1, 32'h0000_7778);
      wait_idle();
      chk(addr_o == 32'h7778, "R8 deferred address wins", addr_o, 32'h7778);
      m_addr = 32'h7778 - 32'(CHUNK);
      check_end("R8 deferred", 16'(CHUNK), 0);
      chk(l == 16'd64, "R3 expected length", {16'd0, l}, 64);

      // R10 disable during transfer: count reaches zero, no interrupt
      cfg_write(2'd2, 32'd16);
      pulse_svc(32'd200, 1'b0);
      cfg_write(2'd0, 32'd0);
      wait_idle();
      m_en = 1'b0;
      check_end("R10 disable mid", 16'd16, 0);
      chk(!en_o, "R10 enable cleared", {31'd0, en_o}, 0);
      cfg_write(2'd0, 32'd1);

      // random mix
      for (int i = 0; i < 60; i++) begin
         if (($urandom % 6) == 0) cfg_write(2'd0, {31'd0, 1'(($urandom % 4) != 0)});
         cfg_write(2'd1, $urandom & 32'h000F_FFFF);
         cfg_write(2'd2, $urandom % 220);
         run_svc($urandom % 300, ($urandom % 5) == 0, "random");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule